// File: doc/BRIEF.md
# L1 Tag Shadow Directory

This block sits beside one bank of a shared cache and keeps a copy of the tags held by several private write-through L1 data caches. Each entry belongs to a given L1 cache, L1 set and L1 way, so the directory mirrors the L1 tag arrays directly. It does not keep a sharer list for each shared-cache line. An L1 line is either valid or invalid, and nothing else.

When an L1 misses on a load, it sends the line address together with the way it is about to replace. The directory writes the new tag into that cache's entry at that set and way, then queues a fill message back to the requester. A store searches the mirrored entries of every L1 at the store's set. Every other L1 holding the line gets an invalidation, and those entries are cleared. The storing cache keeps its own copy and receives an acknowledgement in the same message. All messages leave through one in-order queue, so each L1 sees them in the order the directory made them.

Top module: `shadow_dir`

## Requirements
- R1: After reset every mirrored entry is invalid, `out_valid` is 0 and both request ports are ready.
- R2: An accepted load miss writes the tag at (source L1, set, way) and queues one message with kind 0 (fill), `out_dest` = source, the request address, the reported way and `out_inv` = 0.
- R3: An accepted store queues one message with kind 1 (store acknowledgement), `out_dest` = source, `out_way` = 0. Bit `l1*WAYS+way` of `out_inv` is set exactly when L1 `l1`, other than the source, holds the store's line at that way. The line address is `{tag, set}`, with the set in the low bits.
- R4: The storing L1's own copy is never invalidated and stays valid after its store.
- R5: Every entry named in a store's invalidation vector is cleared when the message is queued.
- R6: A load miss overwrites the chosen way, so the line previously held there is no longer mirrored.
- R7: Messages leave in acceptance order, and a message held by `out_ready` = 0 keeps all fields stable.
- R8: With the queue full, neither port is ready and a waiting request leaves the directory unchanged.
- R9: When both ports are valid, the load is taken and `st_ready` is 0.
- R10: A hit requires the same set as well as the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load-miss request valid |
| ld_ready | output | 1 | Load-miss request accepted this cycle |
| ld_src | input | L1_W | Requesting L1 |
| ld_addr | input | ADDR_W | Line address {tag, set} |
| ld_way | input | WAY_W | L1 way being replaced |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle |
| st_src | input | L1_W | Storing L1 |
| st_addr | input | ADDR_W | Line address {tag, set} |
| out_valid | output | 1 | Message at queue head |
| out_ready | input | 1 | Consumer takes the head message |
| out_kind | output | 1 | 0 fill, 1 store acknowledgement with invalidations |
| out_dest | output | L1_W | L1 receiving the fill or acknowledgement |
| out_addr | output | ADDR_W | Line address of the request |
| out_way | output | WAY_W | Filled way (0 for stores) |
| out_inv | output | NUM_L1*WAYS | Invalidation bit per (L1, way) |

## Verification
On every cycle, the assertions check the handshake rules: full-queue back-pressure, load priority over stores, and message stability while the consumer stalls. They also check that a store never names its own cache in the invalidation vector and that fills carry no invalidations. The bench scenarios are the only evidence that the mirror itself is right. They show which entries a store finds, that entries are cleared and overwritten, that hits depend on the set, and that a blocked store leaves no trace. They do this by comparing invalidation vectors against hand-worked tag histories.

// File: rtl/shadow_dir_pkg.sv
package shadow_dir_pkg;
  typedef enum logic { MSG_FILL = 1'b0, MSG_STORE = 1'b1 } msg_kind_e;

  // flat position of (cache, way) in an invalidation vector
  function automatic int unsigned slot_of(int unsigned l1, int unsigned way, int unsigned ways);
    return l1 * ways + way;
  endfunction

  // flat position of (cache, set, way) in the mirror storage
  function automatic int unsigned entry_of(int unsigned l1, int unsigned set, int unsigned way,
                                           int unsigned sets, int unsigned ways);
    return (l1 * sets + set) * ways + way;
  endfunction
endpackage

// File: rtl/sd_shadow_tags.sv
module sd_shadow_tags
  import shadow_dir_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  localparam int L1_W    = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SLOTS   = NUM_L1 * WAYS,
  localparam int ENTRIES = NUM_L1 * SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [L1_W-1:0]  wr_l1,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [SLOTS-1:0] hit_vec,
  input  logic             clr_en,
  input  logic [SLOTS-1:0] clr_vec
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  for (genvar l = 0; l < NUM_L1; l++) begin : g_l1
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [31:0] idx;
      assign idx = entry_of(l, int'(lk_set), w, SETS, WAYS);
      assign hit_vec[slot_of(l, w, WAYS)] = valid_q[idx] && (tag_q[idx] == lk_tag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[entry_of(int'(wr_l1), int'(wr_set), int'(wr_way), SETS, WAYS)] <= 1'b1;
    end else if (clr_en) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (clr_vec[s])
          valid_q[entry_of(s / WAYS, int'(lk_set), s % WAYS, SETS, WAYS)] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      tag_q[entry_of(int'(wr_l1), int'(wr_set), int'(wr_way), SETS, WAYS)] <= wr_tag;
  end
endmodule

// File: rtl/sd_msg_fifo.sv
module sd_msg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic             full,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem_q[rd_q];
  assign do_pop    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push)   wr_q <= bump(wr_q);
      if (do_pop) rd_q <= bump(rd_q);
      count <= count + CNT_W'(push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/shadow_dir.sv
module shadow_dir
  import shadow_dir_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int QDEPTH = 4,
  localparam int L1_W   = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ADDR_W = TAG_W + SET_W,
  localparam int SLOTS  = NUM_L1 * WAYS,
  localparam int MSG_W  = 1 + L1_W + ADDR_W + WAY_W + SLOTS,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [L1_W-1:0]   ld_src,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [L1_W-1:0]   st_src,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [L1_W-1:0]   out_dest,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WAY_W-1:0]  out_way,
  output logic [SLOTS-1:0]  out_inv
);
  function automatic logic [SET_W-1:0] set_of(logic [ADDR_W-1:0] a);
    return a[SET_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SET_W];
  endfunction

  logic             q_full;
  logic [CNT_W-1:0] q_count;
  logic             ld_fire, st_fire, push;
  logic [SLOTS-1:0] st_hits, own_mask, st_inv_vec;
  logic [MSG_W-1:0] push_msg, head_msg;

  assign ld_ready = !q_full;
  assign st_ready = !q_full && !ld_valid;
  assign ld_fire  = ld_valid && ld_ready;
  assign st_fire  = st_valid && st_ready;
  assign push     = ld_fire || st_fire;

  for (genvar l = 0; l < NUM_L1; l++) begin : g_own
    assign own_mask[l*WAYS +: WAYS] = {WAYS{st_src == L1_W'(l)}};
  end
  assign st_inv_vec = st_hits & ~own_mask;

  sd_shadow_tags #(.NUM_L1(NUM_L1), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_fire), .wr_l1(ld_src), .wr_set(set_of(ld_addr)), .wr_way(ld_way),
    .wr_tag(tag_of(ld_addr)),
    .lk_set(set_of(st_addr)), .lk_tag(tag_of(st_addr)), .hit_vec(st_hits),
    .clr_en(st_fire), .clr_vec(st_inv_vec)
  );

  always_comb begin
    if (ld_fire) push_msg = {MSG_FILL, ld_src, ld_addr, ld_way, {SLOTS{1'b0}}};
    else         push_msg = {MSG_STORE, st_src, st_addr, {WAY_W{1'b0}}, st_inv_vec};
  end

  sd_msg_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_msg),
    .pop(out_ready), .full(q_full), .out_valid(out_valid), .out_data(head_msg),
    .count(q_count)
  );

  assign {out_kind, out_dest, out_addr, out_way, out_inv} = head_msg;
endmodule

// File: rtl/shadow_dir_chk.sv
module shadow_dir_chk #(
  parameter int NUM_L1 = 4,
  parameter int WAYS   = 4,
  parameter int QDEPTH = 4,
  parameter int L1_W   = 2,
  parameter int ADDR_W = 12,
  parameter int WAY_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ld_valid,
  input logic                   ld_ready,
  input logic                   st_ready,
  input logic                   st_fire,
  input logic [L1_W-1:0]        st_src,
  input logic [NUM_L1*WAYS-1:0] st_inv,
  input logic [CNT_W-1:0]       q_count,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_kind,
  input logic [L1_W-1:0]        out_dest,
  input logic [ADDR_W-1:0]      out_addr,
  input logic [WAY_W-1:0]       out_way,
  input logic [NUM_L1*WAYS-1:0] out_inv
);
  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(QDEPTH)) |-> (!ld_ready && !st_ready));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QDEPTH));

  assert_load_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !st_ready);

  assert_keep_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |-> (((st_inv >> (int'(st_src) * WAYS)) & {{(NUM_L1*WAYS-WAYS){1'b0}}, {WAYS{1'b1}}}) == '0));

  assert_fill_no_inval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_kind) |-> (out_inv == '0));

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_kind, out_dest, out_addr, out_way, out_inv})));
endmodule

bind shadow_dir shadow_dir_chk #(
  .NUM_L1(NUM_L1), .WAYS(WAYS), .QDEPTH(QDEPTH), .L1_W(L1_W),
  .ADDR_W(ADDR_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .st_ready(st_ready), .st_fire(st_fire), .st_src(st_src), .st_inv(st_inv_vec),
  .q_count(q_count), .out_valid(out_valid), .out_ready(out_ready),
  .out_kind(out_kind), .out_dest(out_dest), .out_addr(out_addr),
  .out_way(out_way), .out_inv(out_inv)
);

// File: tb/shadow_dir_tb_top.sv
module shadow_dir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, st_valid = 1'b0, out_ready = 1'b1;
  logic [1:0]  ld_src = '0, st_src = '0, ld_way = '0;
  logic [11:0] ld_addr = '0, st_addr = '0;
  logic        ld_ready, st_ready, out_valid, out_kind;
  logic [1:0]  out_dest, out_way;
  logic [11:0] out_addr;
  logic [15:0] out_inv;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_dir dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_src(ld_src), .ld_addr(ld_addr), .ld_way(ld_way),
    .st_valid(st_valid), .st_ready(st_ready), .st_src(st_src), .st_addr(st_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_dest(out_dest),
    .out_addr(out_addr), .out_way(out_way), .out_inv(out_inv)
  );

  // op 0 = load miss, 1 = store; address {tag[7:0], set[3:0]}; inv bit = l1*4+way
  localparam bit          V_OP   [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 1, 1};
  localparam logic [1:0]  V_SRC  [NV] = '{0, 1, 2, 3, 0, 3, 1, 2, 0, 2, 0, 0, 1};
  localparam logic [11:0] V_ADDR [NV] = '{12'h123, 12'h123, 12'h123, 12'h453, 12'h123, 12'h123,
                                          12'h123, 12'h124, 12'h123, 12'h774, 12'h124, 12'h774, 12'h453};
  localparam logic [1:0]  V_WAY  [NV] = '{1, 2, 0, 3, 0, 0, 0, 1, 0, 1, 0, 0, 0};
  localparam logic [15:0] V_INV  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0140, 16'h0002,
                                          16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0200, 16'h8000};
  localparam string       V_REQ  [NV] = '{"R2", "R2", "R2", "R2", "R3", "R4", "R5", "R2", "R10",
                                          "R6", "R6", "R3", "R3"};

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_msg(string req, bit kind, logic [1:0] dest, logic [11:0] addr,
                           logic [1:0] way, logic [15:0] inv);
    logic [32:0] act, exp;
    act = {out_valid, out_kind, out_dest, out_addr, out_way, out_inv};
    exp = {1'b1, kind, dest, addr, way, inv};
    check(act == exp, req, act[31:0], exp[31:0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issue one request, return at the negedge after the accepting edge
  task automatic issue(bit op, logic [1:0] src, logic [11:0] addr, logic [1:0] way);
    if (op) begin st_valid = 1; st_src = src; st_addr = addr; end
    else    begin ld_valid = 1; ld_src = src; ld_addr = addr; ld_way = way; end
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check(!out_valid && ld_ready && st_ready, "R1",
          {out_valid, ld_ready, st_ready}, 3'b011);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_SRC[i], V_ADDR[i], V_WAY[i]);
      check_msg(V_REQ[i], V_OP[i], V_SRC[i], V_ADDR[i], V_OP[i] ? 2'd0 : V_WAY[i], V_INV[i]);
      @(negedge clk);
    end
    check(!out_valid, "R7", out_valid, 0);

    // R9: both ports valid, load wins
    ld_valid = 1; ld_src = 3; ld_addr = 12'h9A5; ld_way = 2;
    st_valid = 1; st_src = 0; st_addr = 12'h9A5;
    #1;
    check(ld_ready && !st_ready, "R9", {ld_ready, st_ready}, 2'b10);
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
    check_msg("R9", 0, 2'd3, 12'h9A5, 2'd2, 16'h0);
    @(negedge clk);
    check(!out_valid, "R9", out_valid, 0);

    // R8: fill the queue with consumer stalled
    out_ready = 0;
    for (int k = 0; k < 4; k++) begin
      ld_valid = 1; ld_src = 1; ld_addr = {4'h6, 4'(k), 4'h1}; ld_way = 2'(k);
      @(negedge clk);
    end
    ld_valid = 0;
    check(!ld_ready && !st_ready, "R8", {ld_ready, st_ready}, 2'b00);
    st_valid = 1; st_src = 0; st_addr = 12'h601;
    repeat (3) @(negedge clk);
    check(!st_ready, "R8", st_ready, 0);
    st_valid = 0;
    // R7: drain in order
    out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      check_msg("R7", 0, 2'd1, {4'h6, 4'(k), 4'h1}, 2'(k), 16'h0);
      @(negedge clk);
    end
    check(!out_valid, "R8", out_valid, 0);
    // blocked store left entries intact: L1 1 way 0 still holds 0x601
    issue(1, 0, 12'h601, 0);
    check_msg("R8", 1, 2'd0, 12'h601, 2'd0, 16'h0010);
    @(negedge clk);

    // R1: reset clears the mirror
    issue(0, 1, 12'h555, 0);
    @(negedge clk);
    do_reset();
    issue(1, 0, 12'h555, 0);
    check_msg("R1", 1, 2'd0, 12'h555, 2'd0, 16'h0000);
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule